// File: doc/BRIEF.md
# Banked Wide-Index Lookup Table

This block is a 2048-entry lookup table assembled from four 512-word memory banks. Each cycle it may accept an 11-bit index. The lower nine bits of that index go to every bank at the same moment, so all four banks read in parallel. The upper two bits ride along in a pipeline register beside the bank reads. In the following stage they pick which bank's word is forwarded to the output.

The table therefore accepts one lookup per clock, the same throughput as a single 2048-word memory. The cost is one extra register stage: a result appears two clocks after its index. A separate write port loads the table. Its upper two address bits enable exactly one bank, and its lower nine bits address a word inside that bank. Reads and writes may occur in the same cycle.

Top module: `bwl_lookup`

## Requirements
- R1: While `rst` is high and after it is released, `out_valid` is 0 and `out_data` is 0 until the first lookup result arrives.
- R2: A lookup of index i returns the word most recently written to write address i, where index and write address use the same 11-bit numbering.
- R3: `out_valid` is 1 exactly two clock edges after a cycle with `in_valid` high, and 0 two edges after a cycle with `in_valid` low.
- R4: Lookups may be issued back to back, one per cycle, and each result appears in issue order, including when consecutive indices fall in different banks.
- R5: A write to address a changes only entry a. Bits [10:9] of the address choose the bank and bits [8:0] choose the word, so entries that share the low nine bits in the other banks keep their contents.
- R6: A lookup and a write to the same address in the same cycle return the contents from before that write. A later lookup returns the new word.
- R7: When a cycle yields no result (`out_valid` 0), `out_data` keeps the last result.
- R8: A write and a lookup to different addresses in the same cycle both take effect: the lookup returns its entry and the write lands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Lookup request this cycle |
| in_index | input | 11 | Lookup index |
| wr_en | input | 1 | Write request this cycle |
| wr_addr | input | 11 | Write address; [10:9] bank, [8:0] word |
| wr_data | input | 16 | Word to write |
| out_valid | output | 1 | Result valid, two cycles after `in_valid` |
| out_data | output | 16 | Looked-up word; held while `out_valid` is 0 |

## Verification
The bench loads every entry with a distinct word and then reads all of them back to back, so that a select register that lags or leads the bank data by one cycle forwards a neighbour's word. It rewrites a single entry and reads the four indices sharing its low nine bits. A write decoder that enabled the wrong bank, or more than one bank, would corrupt one of those siblings. Same-cycle read and write to one address exposes a design that forwards the new word early. Gaps in `in_valid` catch an output register that reloads stale bank contents or that mistimes `out_valid`.

// File: rtl/bwl_pkg.sv
package bwl_pkg;
    localparam int IDX_W   = 11;
    localparam int BANK_AW = 9;
    localparam int DATA_W  = 16;
    localparam int SEL_W   = IDX_W - BANK_AW;
    localparam int NBANK   = 1 << SEL_W;
    localparam int BANK_D  = 1 << BANK_AW;
endpackage

// File: rtl/bwl_bank.sv
module bwl_bank #(
    parameter int AW = 9,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          we,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write port
    always_ff @(posedge clk) begin
        if (we) mem[wr_addr] <= wr_data;
    end

    // Read port: registered, returns contents before a same-edge write
    always_ff @(posedge clk) begin
        if (rd_en) q <= mem[rd_addr];
    end

    // R2
    bank_readback_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(we) && !we && rd_en && (rd_addr == $past(wr_addr)))
        |=> (q == $past(wr_data, 2)));
endmodule

// File: rtl/bwl_sel.sv
module bwl_sel #(
    parameter int NB = 4,
    parameter int SW = 2,
    parameter int DW = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  s1_valid,
    input  logic [SW-1:0]         s1_hi,
    input  logic [NB-1:0][DW-1:0] bank_q,
    output logic                  out_valid,
    output logic [DW-1:0]         out_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) out_data <= bank_q[s1_hi];
        end
    end

    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> $stable(out_data));
endmodule

// File: rtl/bwl_lookup.sv
module bwl_lookup
    import bwl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_index,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic [NBANK-1:0]             bank_we;
    logic [NBANK-1:0][DATA_W-1:0] bank_q;
    logic                         s1_valid;
    logic [SEL_W-1:0]             s1_hi;

    // Stage 1: carry the bank select beside the bank reads
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_hi    <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) s1_hi <= in_index[IDX_W-1:BANK_AW];
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_we[b] = wr_en && (wr_addr[IDX_W-1:BANK_AW] == SEL_W'(b));

        bwl_bank #(.AW(BANK_AW), .DW(DATA_W)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .rd_en   (in_valid),
            .rd_addr (in_index[BANK_AW-1:0]),
            .we      (bank_we[b]),
            .wr_addr (wr_addr[BANK_AW-1:0]),
            .wr_data (wr_data),
            .q       (bank_q[b])
        );
    end

    bwl_sel #(.NB(NBANK), .SW(SEL_W), .DW(DATA_W)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .s1_valid  (s1_valid),
        .s1_hi     (s1_hi),
        .bank_q    (bank_q),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R5
    one_bank_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($countones(bank_we) == 1));

    // R5
    no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> $onehot0(bank_we) && (bank_we == '0));

    // R3
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);

    // R3
    idle_latency_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 !out_valid);
endmodule

// File: tb/sim_bwl_lookup.sv
module sim_bwl_lookup;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [10:0] in_index = '0;
    logic        wr_en = 1'b0;
    logic [10:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    string tag = "R2";

    logic [15:0] ref_mem [2048];
    logic        exp_v [2];
    logic [15:0] exp_d [2];
    logic [15:0] last_d;
    logic        checking = 1'b0;

    always #5 clk = ~clk;

    bwl_lookup u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_index(in_index),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, cycles=%0d expected<150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 40503) ^ 16'h5A3C);
    endfunction

    // One cycle: check outputs, then drive inputs for the next edge.
    task automatic step(input logic iv, input logic [10:0] idx,
                        input logic we, input logic [10:0] wa, input logic [15:0] wd);
        @(negedge clk);
        if (checking) begin
            n_tests++;
            if (out_valid !== exp_v[1]) begin
                n_fail++;
                $display("FAIL R3: out_valid=%0b expected=%0b", out_valid, exp_v[1]);
            end
            if (exp_v[1]) last_d = exp_d[1];
            n_tests++;
            if (out_data !== last_d) begin
                n_fail++;
                $display("FAIL %s: out_data=%h expected=%h (valid=%0b, R7 hold if 0)",
                         tag, out_data, last_d, exp_v[1]);
            end
        end
        exp_v[1] = exp_v[0];
        exp_d[1] = exp_d[0];
        exp_v[0] = iv;
        exp_d[0] = ref_mem[idx];
        if (we) ref_mem[wa] = wd;
        in_valid = iv;
        in_index = idx;
        wr_en    = we;
        wr_addr  = wa;
        wr_data  = wd;
    endtask

    task automatic rd(input int idx);
        step(1'b1, 11'(idx), 1'b0, '0, '0);
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        step(1'b0, '0, 1'b1, 11'(a), d);
    endtask

    task automatic idle();
        step(1'b0, '0, 1'b0, '0, '0);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) ref_mem[i] = '0;
        exp_v[0] = 0; exp_v[1] = 0; exp_d[0] = '0; exp_d[1] = '0;
        last_d = '0;
        for (int i = 0; i < 4; i++) idle();
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        n_tests++;
        if (out_valid !== 1'b0 || out_data !== 16'h0) begin
            n_fail++;
            $display("FAIL R1: out_valid=%0b out_data=%h expected=0 0000", out_valid, out_data);
        end
        checking = 1'b1;
        tag = "R1";
        for (int i = 0; i < 3; i++) idle();

        // Fill every entry (R5 addressing)
        tag = "R5";
        for (int i = 0; i < 2048; i++) wr(i, pat(i));
        idle(); idle();

        // R2 / R4: back-to-back full sweep
        tag = "R4";
        for (int i = 0; i < 2048; i++) rd(i);
        // R4: alternate banks every cycle
        for (int i = 0; i < 512; i++) rd(((i % 4) * 512) + ((i * 7) % 512));
        idle(); idle();

        // R3 / R7: sparse valid
        tag = "R7";
        for (int i = 0; i < 40; i++) begin
            rd((i * 97) % 2048);
            for (int k = 0; k < (i % 3); k++) idle();
        end
        idle(); idle();

        // R5: rewrite one entry, siblings in other banks unchanged
        tag = "R5";
        wr(2 * 512 + 7, 16'hBEEF);
        rd(7); rd(512 + 7); rd(1024 + 7); rd(1536 + 7);
        idle(); idle();

        // R6: read and write same address in one cycle
        tag = "R6";
        step(1'b1, 11'd300, 1'b1, 11'd300, 16'hC0DE);
        rd(300);
        idle(); idle();

        // R8: write and read different addresses same cycle
        tag = "R8";
        step(1'b1, 11'd1800, 1'b1, 11'd1801, 16'h1234);
        rd(1801); rd(1800);
        idle(); idle();

        // R2: random mix of reads and writes
        tag = "R2";
        for (int i = 0; i < 3000; i++)
            step(1'($urandom % 2), 11'($urandom), 1'($urandom % 2),
                 11'($urandom), 16'($urandom));
        idle(); idle(); idle();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule